// File: doc/BRIEF.md
# Peripheral Run-State Controller

This block holds the operating state of a serial peripheral core. The core is always in one of three states: held in reset, running, or paused. Software asks for a new state by writing a two-bit code to the state register. The block then lowers a valid flag while the change settles. It commits the new state and raises the flag again after a fixed, parameterised number of cycles. A read of the register always returns the committed state code and the valid flag.

A typical transfer moves from reset to run, then to pause while data is loaded, then back to run. When the transfer is complete it returns to reset. Leaving pause for reset is guarded: it takes two back-to-back writes of the clear code, so that a single stray write cannot abort a paused transfer. A separate soft-reset register, written with 1, forces the reset state at once. The `core_running_o` output tells the serial datapath when it may shift.

Top module: `run_state_ctrl`

## Requirements
- R1: After reset is asserted, the read value is state code 0 (reset) with valid (bit 2) set, and `core_running_o` is low.
- R2: A state write of code 0 (reset), 1 (run) or 3 (pause) made while valid is set is accepted, except a write of 0 from pause. Valid then reads 0 for exactly SETTLE_CYC cycles after the write edge, while the state field keeps the old code. On the next edge valid reads 1 and the state field holds the new code.
- R3: Any state write made while valid is low is ignored. It changes neither the outcome nor the timing of the transition in progress.
- R4: A write of code 2 (clear) from reset or run is ignored, and so is a write of code 0 from pause. Valid stays set, the state is unchanged, and the pending clear count is discarded.
- R5: From pause, a single write of code 2 changes nothing and valid stays set. A second write of code 2, with no other state write in between, is accepted and moves the block to reset with the normal settle time. Any other state write in between cancels the first clear.
- R6: A write of 1 to the soft-reset register forces state 0 with valid set on the next cycle. It cancels any transition in progress and any pending clear. A write of 0 to that register has no effect.
- R7: `core_running_o` is high exactly when the committed state is run (code 1).
- R8: Valid always returns within SETTLE_CYC cycles of an accepted write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| state_wr_i | input | 1 | Write strobe for the state register |
| state_wdata_i | input | 2 | Requested state code |
| sreset_wr_i | input | 1 | Write strobe for the soft-reset register |
| sreset_wdata_i | input | 1 | Soft-reset write data; 1 forces the reset state |
| state_rdata_o | output | 3 | Read value: bit 2 is valid, bits 1:0 are the committed state |
| core_running_o | output | 1 | High while the committed state is run |

## Verification
The assertions check on every cycle that the settle counter only counts down and never exceeds its limit. They also check that a transition starts only while the block is idle, that the committed state changes only at the end of a settle or on a soft reset, and that a lone clear from pause or a clear from another state leaves valid set. The bench's scenarios are needed to show the rest. These include the full matrix of start state against written code, the exact cycle in which valid returns with the new code, and a first clear cancelled by an intervening write. They also cover a soft reset that aborts a transition in flight, and writes dropped while valid is low.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
  typedef enum logic [1:0] {
    ST_RESET = 2'd0,
    ST_RUN   = 2'd1,
    ST_CLEAR = 2'd2,
    ST_PAUSE = 2'd3
  } run_state_e;
endpackage

// File: rtl/rsc_wr_decode.sv
module rsc_wr_decode
  import rsc_pkg::*;
(
  input  run_state_e cur_i,
  input  logic       valid_i,
  input  logic       wr_i,
  input  logic [1:0] wdata_i,
  input  logic       armed_i,
  output logic       accept_o,
  output run_state_e target_o,
  output logic       arm_set_o,
  output logic       arm_clr_o
);
  always_comb begin
    accept_o  = 1'b0;
    target_o  = run_state_e'(wdata_i);
    arm_set_o = 1'b0;
    arm_clr_o = 1'b0;
    if (wr_i && valid_i) begin
      if (wdata_i == ST_CLEAR) begin
        if (cur_i == ST_PAUSE) begin
          if (armed_i) begin
            accept_o  = 1'b1;
            target_o  = ST_RESET;
            arm_clr_o = 1'b1;
          end else begin
            arm_set_o = 1'b1;
          end
        end else begin
          arm_clr_o = 1'b1;
        end
      end else begin
        arm_clr_o = 1'b1;
        // pause may only reach reset through the double clear
        if (!(cur_i == ST_PAUSE && wdata_i == ST_RESET)) accept_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/rsc_clear_seq.sv
module rsc_clear_seq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic srst_i,
  input  logic arm_set_i,
  input  logic arm_clr_i,
  output logic armed_o
);
  logic armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        armed_q <= 1'b0;
    else if (srst_i)    armed_q <= 1'b0;
    else if (arm_clr_i) armed_q <= 1'b0;
    else if (arm_set_i) armed_q <= 1'b1;
  end

  assign armed_o = armed_q;

  // R5
  arm_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(arm_set_i && arm_clr_i));

  // R6
  srst_disarm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_i |=> !armed_q);
endmodule

// File: rtl/rsc_settle_timer.sv
module rsc_settle_timer #(
  parameter int SETTLE_CYC = 4,
  localparam int CNT_W = $clog2(SETTLE_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic srst_i,
  input  logic start_i,
  output logic valid_o,
  output logic commit_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (srst_i)          cnt_q <= '0;
    else if (start_i)         cnt_q <= CNT_W'(SETTLE_CYC);
    else if (cnt_q != '0)     cnt_q <= cnt_q - CNT_W'(1);
  end

  assign valid_o  = (cnt_q == '0);
  assign commit_o = (cnt_q == CNT_W'(1)) && !srst_i;

  // R3
  start_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> cnt_q == '0);

  // R8
  count_down_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0 && !srst_i) |=> cnt_q == $past(cnt_q) - CNT_W'(1));

  // R8
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(SETTLE_CYC));
endmodule

// File: rtl/run_state_ctrl.sv
module run_state_ctrl
  import rsc_pkg::*;
#(
  parameter int SETTLE_CYC = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       state_wr_i,
  input  logic [1:0] state_wdata_i,
  input  logic       sreset_wr_i,
  input  logic       sreset_wdata_i,
  output logic [2:0] state_rdata_o,
  output logic       core_running_o
);
  run_state_e cur_q, pend_q, target;
  logic valid, commit, accept, arm_set, arm_clr, armed, srst_fire, start;

  assign srst_fire = sreset_wr_i && sreset_wdata_i;
  assign start     = accept && !srst_fire;

  rsc_wr_decode u_dec (
    .cur_i     (cur_q),
    .valid_i   (valid),
    .wr_i      (state_wr_i),
    .wdata_i   (state_wdata_i),
    .armed_i   (armed),
    .accept_o  (accept),
    .target_o  (target),
    .arm_set_o (arm_set),
    .arm_clr_o (arm_clr)
  );

  rsc_clear_seq u_clr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .srst_i    (srst_fire),
    .arm_set_i (arm_set),
    .arm_clr_i (arm_clr),
    .armed_o   (armed)
  );

  rsc_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .srst_i   (srst_fire),
    .start_i  (start),
    .valid_o  (valid),
    .commit_o (commit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q  <= ST_RESET;
      pend_q <= ST_RESET;
    end else begin
      if (srst_fire)   cur_q <= ST_RESET;
      else if (commit) cur_q <= pend_q;
      if (start)       pend_q <= target;
    end
  end

  assign state_rdata_o  = {valid, cur_q};
  assign core_running_o = (cur_q == ST_RUN);

  // R2
  commit_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cur_q) |-> ($past(commit) || $past(srst_fire)));

  // R4
  clear_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid && state_wr_i && state_wdata_i == ST_CLEAR && cur_q != ST_PAUSE && !srst_fire)
      |=> (state_rdata_o[2] && $stable(cur_q)));

  // R5
  single_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid && state_wr_i && state_wdata_i == ST_CLEAR && cur_q == ST_PAUSE && !armed && !srst_fire)
      |=> state_rdata_o[2]);

  // R6
  srst_force_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_fire |=> (state_rdata_o == 3'b100));
endmodule

// File: tb/run_state_ctrl_tb.sv
module run_state_ctrl_tb;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic st_wr = 1'b0;
  logic [1:0] st_d = '0;
  logic sr_wr = 1'b0;
  logic sr_d = 1'b0;
  logic [2:0] rdata;
  logic running;
  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  run_state_ctrl #(.SETTLE_CYC(N)) u_dut (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .state_wr_i     (st_wr),
    .state_wdata_i  (st_d),
    .sreset_wr_i    (sr_wr),
    .sreset_wdata_i (sr_d),
    .state_rdata_o  (rdata),
    .core_running_o (running)
  );

  // {running, valid, state}; running per R7
  function automatic logic [3:0] exp_obs(input logic [1:0] s, input logic v);
    return {s == 2'd1, v, s};
  endfunction

  task automatic chk(input string req, input logic [3:0] exp);
    logic [3:0] act;
    act = {running, rdata};
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr_st(input logic [1:0] code, input logic acc,
                       input logic [1:0] old_s, input logic [1:0] tgt, input string req);
    @(negedge clk); st_wr = 1'b1; st_d = code;
    @(negedge clk); st_wr = 1'b0;
    if (acc) begin
      for (int i = 0; i < N; i++) begin
        chk(req, exp_obs(old_s, 1'b0));
        @(negedge clk);
      end
      chk(req, exp_obs(tgt, 1'b1));
    end else begin
      chk(req, exp_obs(old_s, 1'b1));
      @(negedge clk);
      chk(req, exp_obs(old_s, 1'b1));
    end
  endtask

  task automatic soft_rst(input logic d, input logic [1:0] exp_s);
    @(negedge clk); sr_wr = 1'b1; sr_d = d;
    @(negedge clk); sr_wr = 1'b0;
    chk("R6", exp_obs(exp_s, 1'b1));
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog act=hung exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [1:0] st_list [3];
    st_list[0] = 2'd0; st_list[1] = 2'd1; st_list[2] = 2'd3;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1", exp_obs(2'd0, 1'b1));

    // sweep: start state x written code (R2, R4, R5, R7, R8)
    for (int si = 0; si < 3; si++) begin
      for (int c = 0; c < 4; c++) begin
        logic [1:0] s;
        logic acc;
        s = st_list[si];
        soft_rst(1'b1, 2'd0);
        if (s != 2'd0) wr_st(s, 1'b1, 2'd0, s, "R2");
        acc = (c != 2) && !(s == 2'd3 && c == 0);
        if (c == 2 && s == 2'd3)      wr_st(2'(c), acc, s, s, "R5");
        else if (!acc)                wr_st(2'(c), acc, s, s, "R4");
        else                          wr_st(2'(c), acc, s, 2'(c), "R8");
      end
    end

    // double clear from pause (R5)
    soft_rst(1'b1, 2'd0);
    wr_st(2'd3, 1'b1, 2'd0, 2'd3, "R2");
    wr_st(2'd2, 1'b0, 2'd3, 2'd3, "R5");
    wr_st(2'd2, 1'b1, 2'd3, 2'd0, "R5");

    // cancelled clear: clear, run, pause, clear -> ignored (R5)
    wr_st(2'd3, 1'b1, 2'd0, 2'd3, "R2");
    wr_st(2'd2, 1'b0, 2'd3, 2'd3, "R5");
    wr_st(2'd1, 1'b1, 2'd3, 2'd1, "R5");
    wr_st(2'd3, 1'b1, 2'd1, 2'd3, "R2");
    wr_st(2'd2, 1'b0, 2'd3, 2'd3, "R5");
    // ignored reset code also cancels (R4, R5)
    wr_st(2'd0, 1'b0, 2'd3, 2'd3, "R4");
    wr_st(2'd2, 1'b0, 2'd3, 2'd3, "R5");
    wr_st(2'd2, 1'b1, 2'd3, 2'd0, "R5");

    // write while valid low is dropped (R3)
    @(negedge clk); st_wr = 1'b1; st_d = 2'd1;
    @(negedge clk); st_d = 2'd3;
    @(negedge clk); st_wr = 1'b0;
    chk("R3", exp_obs(2'd0, 1'b0));
    repeat (N) @(negedge clk);
    chk("R3", exp_obs(2'd1, 1'b1));

    // soft reset with data 0 ignored (R6)
    soft_rst(1'b0, 2'd1);

    // soft reset aborts transition in flight (R6)
    @(negedge clk); st_wr = 1'b1; st_d = 2'd3;
    @(negedge clk); st_wr = 1'b0; sr_wr = 1'b1; sr_d = 1'b1;
    @(negedge clk); sr_wr = 1'b0;
    chk("R6", exp_obs(2'd0, 1'b1));
    repeat (N + 1) @(negedge clk);
    chk("R6", exp_obs(2'd0, 1'b1));

    // hardware reset from run (R1)
    wr_st(2'd1, 1'b1, 2'd0, 2'd1, "R7");
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    chk("R1", exp_obs(2'd0, 1'b1));

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule